// File: doc/BRIEF.md
# Stripe-Parallel Bitplane Scanner

This block turns a small codeblock of signed wavelet coefficients into the symbol stream that an entropy coder consumes. The coefficients are written into a local buffer through a word-wide load port. A start pulse then sweeps the bitplanes from the most significant occupied plane down to plane 0. Each plane gets two passes: a significance pass and then a refinement pass. Every symbol carries the coded bit, a context, the bitplane, the stripe it came from and an optional probability.

The codeblock is cut into vertical stripes, each two columns wide. All stripes step through the same row and column position together. At each step, the symbols of the stripes are serialised onto one valid/ready stream in ascending stripe order. Two coefficients visited in the same step are always two columns apart, so they are never neighbours, and the serialisation cannot change any context. Each coefficient word holds two status flags, significant and refine, in bits that the magnitude never uses.

Top module: `bps_scan`

## Requirements
- R1: After reset, `sym_valid_o` and `done_o` are low until a scan is started.
- R2: Within one pass, positions are visited row 0 to the last row. Within a row, the left column of a stripe comes before its right column. At each position, stripes are serialised in ascending order. `sym_stripe_o` is the column index divided by two. Load address = row × (2·N_STRIPES) + column.
- R3: Planes run from M−1 down to 0. M is the smallest bit count that holds the largest magnitude (word bits 27:0). If every magnitude is zero, the scan ends with `done_o` and emits no symbol.
- R4: In the significance pass, a coefficient whose significant flag is clear emits a symbol of kind 0 whose bit is magnitude bit j. Its context is the number of significant coefficients among its eight neighbours, counted across stripe borders. Positions outside the codeblock count as not significant.
- R5: When a kind-0 bit of 1 is accepted, the coefficient becomes significant. The very next symbol is kind 1, whose bit is word bit 31 (1 = negative). Its context is 4 + P − Q, where P and Q count the significant positive and negative coefficients among the top, bottom, left and right neighbours.
- R6: In the refinement pass, a coefficient with its refine flag set emits kind 2 with magnitude bit j and context 0. A significant coefficient whose refine flag is clear emits nothing and gets the flag set, so its first refinement comes one plane lower.
- R7: `sym_prob_o` equals ((ctx·37 + j·11 + base) mod 256) XOR 0x5A. The base is 0 for kind 0, 100 for kind 1 and 200 for kind 2.
- R8: While `sym_valid_o` is high and `sym_ready_i` is low, the symbol fields hold and no state advances.
- R9: `done_o` is high for exactly one cycle, after the refinement pass of plane 0. No symbol is presented while it is high.
- R10: A load clears both status flags of the addressed word. Load data bits 30:28 are ignored. Loads and start pulses are ignored while a scan runs. Status flags persist across a restart that has no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Write one coefficient word |
| load_addr_i | input | ADDR_W | Coefficient address, row-major |
| load_data_i | input | 32 | Sign in bit 31, magnitude in bits 27:0 |
| start_i | input | 1 | Begin a scan |
| sym_valid_o | output | 1 | Symbol presented |
| sym_ready_i | input | 1 | Consumer accepts the symbol |
| sym_bit_o | output | 1 | Coded bit |
| sym_kind_o | output | 2 | 0 significance, 1 sign, 2 refinement |
| sym_ctx_o | output | 4 | Context, 0 to 8 |
| sym_plane_o | output | PLANE_W | Bitplane index |
| sym_stripe_o | output | STR_W | Source stripe |
| sym_prob_o | output | PROB_W | Probability from the table |
| done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
The bench builds the block with four stripes and eight rows, a 64-word buffer and the full 28-bit magnitude range, with the table enabled. This size places interior coefficients with all eight neighbours, stripe borders on both sides and corners within a few thousand cycles. Full-range magnitudes reach plane 27, and magnitudes limited to two bits make significance spread densely through many neighbours. Random backpressure, and loads and starts issued in the middle of a scan, exercise the stall and ignore paths against a reference model that keeps its own status flags across restarts.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    SYM_SIG  = 2'd0,
    SYM_SIGN = 2'd1,
    SYM_REF  = 2'd2
  } sym_kind_e;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SIGN_POS = 31;
  localparam int unsigned REF_POS  = 30;
  localparam int unsigned SIG_POS  = 29;
  localparam int unsigned CTX_W    = 4;
endpackage

// File: rtl/bps_msb.sv
module bps_msb #(
  parameter int unsigned CELLS = 64,
  parameter int unsigned MAG_W = 28,
  parameter int unsigned CNT_W = $clog2(MAG_W + 1)
) (
  input  logic [CELLS*MAG_W-1:0] mags_i,
  output logic [CNT_W-1:0]       cnt_o
);
  logic [MAG_W-1:0] acc;

  // OR across the block: highest set bit equals that of the maximum
  always_comb begin
    acc = '0;
    for (int i = 0; i < int'(CELLS); i++) acc |= mags_i[i*MAG_W +: MAG_W];
    cnt_o = '0;
    for (int b = 0; b < int'(MAG_W); b++) if (acc[b]) cnt_o = CNT_W'(b + 1);
  end
endmodule

// File: rtl/bps_ctx.sv
module bps_ctx #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned COLS  = 8,
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_W = 3,
  localparam int unsigned CELLS = ROWS * COLS,
  localparam int unsigned IDX_W = $clog2(CELLS)
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [CELLS-1:0] sig_map_i,
  input  logic [CELLS-1:0] neg_map_i,
  output logic [3:0]       sig_ctx_o,
  output logic [3:0]       sgn_ctx_o
);
  always_comb begin
    int cnt, pos, neg, r, c;
    logic [IDX_W-1:0] idx;
    cnt = 0; pos = 0; neg = 0; idx = '0;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        r = int'(row_i) + dr;
        c = int'(col_i) + dc;
        if (!(dr == 0 && dc == 0) && r >= 0 && r < int'(ROWS) && c >= 0 && c < int'(COLS)) begin
          idx = IDX_W'(r * int'(COLS) + c);
          if (sig_map_i[idx]) begin
            cnt++;
            if (dr == 0 || dc == 0) begin
              if (neg_map_i[idx]) neg++;
              else pos++;
            end
          end
        end
      end
    end
    sig_ctx_o = 4'(cnt);
    sgn_ctx_o = 4'(4 + pos - neg);
  end
endmodule

// File: rtl/bps_prob.sv
module bps_prob
  import bps_pkg::*;
#(
  parameter bit          USE_PROB = 1'b1,
  parameter int unsigned PROB_W   = 8,
  parameter int unsigned PLANE_W  = 5
) (
  input  sym_kind_e          kind_i,
  input  logic [3:0]         ctx_i,
  input  logic [PLANE_W-1:0] plane_i,
  output logic [PROB_W-1:0]  prob_o
);
  if (USE_PROB) begin : g_lut
    logic [15:0] raw;
    logic [15:0] base;
    always_comb begin
      case (kind_i)
        SYM_SIGN: base = 16'd100;
        SYM_REF:  base = 16'd200;
        default:  base = 16'd0;
      endcase
      raw    = 16'(ctx_i) * 16'd37 + 16'(plane_i) * 16'd11 + base;
      prob_o = PROB_W'(raw[7:0] ^ 8'h5A);
    end
  end else begin : g_none
    assign prob_o = '0;
  end
endmodule

// File: rtl/bps_scan.sv
module bps_scan
  import bps_pkg::*;
#(
  parameter int unsigned N_STRIPES = 4,
  parameter int unsigned ROWS      = 8,
  parameter int unsigned MAG_W     = 28,
  parameter int unsigned PROB_W    = 8,
  parameter bit          USE_PROB  = 1'b1,
  localparam int unsigned COLS     = 2 * N_STRIPES,
  localparam int unsigned CELLS    = ROWS * COLS,
  localparam int unsigned ADDR_W   = $clog2(CELLS),
  localparam int unsigned STR_W    = (N_STRIPES > 1) ? $clog2(N_STRIPES) : 1,
  localparam int unsigned COL_W    = STR_W + 1,
  localparam int unsigned ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned PLANE_W  = $clog2(MAG_W),
  localparam int unsigned CNT_W    = $clog2(MAG_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic [ADDR_W-1:0]  load_addr_i,
  input  logic [31:0]        load_data_i,
  input  logic               start_i,
  output logic               sym_valid_o,
  input  logic               sym_ready_i,
  output logic               sym_bit_o,
  output logic [1:0]         sym_kind_o,
  output logic [3:0]         sym_ctx_o,
  output logic [PLANE_W-1:0] sym_plane_o,
  output logic [STR_W-1:0]   sym_stripe_o,
  output logic [PROB_W-1:0]  sym_prob_o,
  output logic               done_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_SIG, ST_REF, ST_DONE} state_e;

  localparam logic [31:0] LOAD_MASK = {1'b1, 31'((64'd1 << MAG_W) - 64'd1)};

  state_e             state_q;
  logic [PLANE_W-1:0] plane_q;
  logic [ROW_W-1:0]   row_q;
  logic               col_q;
  logic [STR_W-1:0]   str_q;
  logic               sign_ph_q;
  logic [31:0]        mem_q [CELLS];

  logic [CELLS*MAG_W-1:0] mags_flat;
  logic [CELLS-1:0]       sig_map, neg_map;
  logic [CNT_W-1:0]       top_cnt;
  logic [COL_W-1:0]       cur_col;
  logic [ADDR_W-1:0]      cur_idx;
  logic [31:0]            word;
  logic [3:0]             sig_ctx, sgn_ctx;
  sym_kind_e              kind;
  logic                   fire, step, last_pos, new_sig, mark_ref;

  for (genvar g = 0; g < int'(CELLS); g++) begin : g_map
    assign mags_flat[g*MAG_W +: MAG_W] = mem_q[g][MAG_W-1:0];
    assign sig_map[g] = mem_q[g][SIG_POS];
    assign neg_map[g] = mem_q[g][SIGN_POS];
  end

  bps_msb #(.CELLS(CELLS), .MAG_W(MAG_W), .CNT_W(CNT_W)) u_msb (
    .mags_i(mags_flat), .cnt_o(top_cnt)
  );

  assign cur_col = {str_q, col_q};
  assign cur_idx = ADDR_W'(int'(row_q) * int'(COLS) + int'(cur_col));
  assign word    = mem_q[cur_idx];

  bps_ctx #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctx (
    .row_i(row_q), .col_i(cur_col), .sig_map_i(sig_map), .neg_map_i(neg_map),
    .sig_ctx_o(sig_ctx), .sgn_ctx_o(sgn_ctx)
  );

  always_comb begin
    sym_valid_o = 1'b0;
    kind        = SYM_SIG;
    sym_bit_o   = 1'b0;
    sym_ctx_o   = '0;
    if (state_q == ST_SIG) begin
      if (sign_ph_q) begin
        sym_valid_o = 1'b1; kind = SYM_SIGN;
        sym_bit_o = word[SIGN_POS]; sym_ctx_o = sgn_ctx;
      end else if (!word[SIG_POS]) begin
        sym_valid_o = 1'b1; kind = SYM_SIG;
        sym_bit_o = word[plane_q]; sym_ctx_o = sig_ctx;
      end
    end else if (state_q == ST_REF && word[REF_POS]) begin
      sym_valid_o = 1'b1; kind = SYM_REF; sym_bit_o = word[plane_q];
    end
  end

  assign sym_kind_o   = kind;
  assign sym_plane_o  = plane_q;
  assign sym_stripe_o = str_q;
  assign done_o       = (state_q == ST_DONE);

  bps_prob #(.USE_PROB(USE_PROB), .PROB_W(PROB_W), .PLANE_W(PLANE_W)) u_prob (
    .kind_i(kind), .ctx_i(sym_ctx_o), .plane_i(plane_q), .prob_o(sym_prob_o)
  );

  assign fire     = sym_valid_o && sym_ready_i;
  assign new_sig  = fire && kind == SYM_SIG && sym_bit_o;
  assign mark_ref = state_q == ST_REF && word[SIG_POS] && !word[REF_POS];
  assign step     = (state_q == ST_SIG || state_q == ST_REF) && (!sym_valid_o || (fire && !new_sig));
  assign last_pos = row_q == ROW_W'(ROWS - 1) && col_q && str_q == STR_W'(N_STRIPES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      plane_q   <= '0;
      row_q     <= '0;
      col_q     <= 1'b0;
      str_q     <= '0;
      sign_ph_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          row_q <= '0; col_q <= 1'b0; str_q <= '0; sign_ph_q <= 1'b0;
          if (top_cnt == '0) state_q <= ST_DONE;
          else begin
            plane_q <= PLANE_W'(top_cnt - CNT_W'(1));
            state_q <= ST_SIG;
          end
        end
        ST_SIG, ST_REF: begin
          if (new_sig) sign_ph_q <= 1'b1;
          if (step) begin
            sign_ph_q <= 1'b0;
            // stripes innermost, then column, then row
            if (str_q == STR_W'(N_STRIPES - 1)) begin
              str_q <= '0;
              if (col_q) begin
                col_q <= 1'b0;
                row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + ROW_W'(1);
              end else col_q <= 1'b1;
            end else str_q <= str_q + STR_W'(1);
            if (last_pos) begin
              if (state_q == ST_SIG) state_q <= ST_REF;
              else if (plane_q == '0) state_q <= ST_DONE;
              else begin
                plane_q <= plane_q - PLANE_W'(1);
                state_q <= ST_SIG;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (state_q == ST_IDLE && load_en_i && int'(load_addr_i) < int'(CELLS))
      mem_q[load_addr_i] <= load_data_i & LOAD_MASK;
    else if (state_q == ST_SIG && new_sig)
      mem_q[cur_idx][SIG_POS] <= 1'b1;
    else if (mark_ref)
      mem_q[cur_idx][REF_POS] <= 1'b1;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o && !sym_ready_i |=> sym_valid_o && $stable(sym_bit_o) && $stable(sym_kind_o)
      && $stable(sym_ctx_o) && $stable(sym_plane_o) && $stable(sym_stripe_o));
  // R5
  sign_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o && sym_ready_i && sym_kind_o == SYM_SIG && sym_bit_o
      |=> sym_valid_o && sym_kind_o == SYM_SIGN);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sym_valid_o);
  // R3
  plane_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SIG || state_q == ST_REF) && $past(state_q) != ST_IDLE
      |-> plane_q <= $past(plane_q));
endmodule

// File: tb/bps_scan_bench.sv
module bps_scan_bench;
  localparam int N = 4, ROWS = 8, COLS = 8, CELLS = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        load_en = 1'b0, start = 1'b0, sym_ready = 1'b1;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic        sym_valid, sym_bit, done;
  logic [1:0]  sym_kind;
  logic [3:0]  sym_ctx;
  logic [4:0]  sym_plane;
  logic [1:0]  sym_stripe;
  logic [7:0]  sym_prob;

  bps_scan u_bps_scan (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_addr_i(load_addr),
    .load_data_i(load_data), .start_i(start), .sym_valid_o(sym_valid),
    .sym_ready_i(sym_ready), .sym_bit_o(sym_bit), .sym_kind_o(sym_kind),
    .sym_ctx_o(sym_ctx), .sym_plane_o(sym_plane), .sym_stripe_o(sym_stripe),
    .sym_prob_o(sym_prob), .done_o(done)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0, cycles = 0, done_cnt = 0, sym_cnt = 0;
  bit bp_mode = 1'b0, prev_stall = 1'b0, prev_done = 1'b0;
  logic [13:0] prev_act;
  logic [27:0] m_mag [CELLS];
  bit m_neg [CELLS], m_sig [CELLS], m_ref [CELLS];
  logic [21:0] exp_q [$];

  task automatic check(bit ok, string req, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] prob_of(int kind, int ctx, int plane);
    int base = (kind == 0) ? 0 : (kind == 1) ? 100 : 200;
    return 8'(((ctx * 37 + plane * 11 + base) % 256) ^ 'h5A);
  endfunction

  function automatic void push(int kind, bit b, int ctx, int plane, int stripe);
    exp_q.push_back({prob_of(kind, ctx, plane), 2'(kind), b, 4'(ctx), 5'(plane), 2'(stripe)});
  endfunction

  function automatic bit in_blk(int r, int c);
    return r >= 0 && r < ROWS && c >= 0 && c < COLS;
  endfunction

  function automatic void model_scan();
    logic [27:0] all_or = '0;
    int m = 0;
    for (int i = 0; i < CELLS; i++) all_or |= m_mag[i];
    for (int b = 0; b < 28; b++) if (all_or[b]) m = b + 1;
    for (int j = m - 1; j >= 0; j--) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < N; s++) begin
            int x = 2 * s + c, id = r * COLS + x, cnt = 0, sc = 4;
            if (!m_sig[id]) begin
              for (int dr = -1; dr <= 1; dr++)
                for (int dc = -1; dc <= 1; dc++)
                  if ((dr != 0 || dc != 0) && in_blk(r + dr, x + dc) && m_sig[(r + dr) * COLS + x + dc]) cnt++;
              push(0, m_mag[id][j], cnt, j, s);
              if (m_mag[id][j]) begin
                m_sig[id] = 1'b1;
                if (in_blk(r - 1, x) && m_sig[id - COLS]) sc += m_neg[id - COLS] ? -1 : 1;
                if (in_blk(r + 1, x) && m_sig[id + COLS]) sc += m_neg[id + COLS] ? -1 : 1;
                if (in_blk(r, x - 1) && m_sig[id - 1]) sc += m_neg[id - 1] ? -1 : 1;
                if (in_blk(r, x + 1) && m_sig[id + 1]) sc += m_neg[id + 1] ? -1 : 1;
                push(1, m_neg[id], sc, j, s);
              end
            end
          end
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < N; s++) begin
            int id = r * COLS + 2 * s + c;
            if (m_ref[id]) push(2, m_mag[id][j], 0, j, s);
            else if (m_sig[id]) m_ref[id] = 1'b1;
          end
    end
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      check(1'b0, "watchdog", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // monitor: pops expected symbols on every accepted one
  always @(negedge clk) begin
    if (rst_n) begin
      logic [13:0] act;
      act = {sym_kind, sym_bit, sym_ctx, sym_plane, sym_stripe};
      if (prev_stall) check(sym_valid && act == prev_act, "R8 stall hold", {sym_valid, act}, {1'b1, prev_act});
      sym_ready = bp_mode ? ($urandom_range(3) != 0) : 1'b1;
      if (sym_valid && sym_ready) begin
        sym_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected symbol", act, 0);
        else begin
          logic [21:0] e;
          string rq;
          e  = exp_q.pop_front();
          rq = (e[13:12] == 2'd0) ? "R4 R2 sig" : (e[13:12] == 2'd1) ? "R5 sign" : "R6 refine";
          check(act == e[13:0], rq, act, e[13:0]);
          check(sym_prob == e[21:14], "R7 prob", sym_prob, e[21:14]);
        end
      end
      prev_stall = sym_valid && !sym_ready;
      prev_act   = act;
      if (done) begin
        done_cnt++;
        check(!prev_done && !sym_valid, "R9 single done", {prev_done, sym_valid}, 0);
        check(exp_q.size() == 0, "R9 done after last symbol", exp_q.size(), 0);
      end
      prev_done = done;
    end
  end

  task automatic load_block(logic [31:0] w [CELLS]);
    for (int i = 0; i < CELLS; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = 6'(i); load_data = w[i];
      m_mag[i] = w[i][27:0]; m_neg[i] = w[i][31]; m_sig[i] = 1'b0; m_ref[i] = 1'b0;
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_scan(string tag, bit interfere);
    int d0 = done_cnt, t = 0;
    model_scan();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (done_cnt == d0 && t < 40000) begin
      @(negedge clk);
      t++;
      if (interfere && t == 5) begin
        load_en = 1'b1; load_addr = 6'd0; load_data = 32'h0FFF_FFFF; start = 1'b1;
      end else begin
        load_en = 1'b0; start = 1'b0;
      end
    end
    check(done_cnt == d0 + 1, {tag, " R9 done seen"}, done_cnt - d0, 1);
    check(exp_q.size() == 0, {tag, " R3 all symbols"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] w [CELLS];
    int s0;
    repeat (3) @(negedge clk);
    // R1
    check(!sym_valid && !done, "R1 reset outputs", {sym_valid, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!sym_valid && !done, "R1 idle after reset", {sym_valid, done}, 0);

    // R3: empty block gives done and no symbol
    foreach (w[i]) w[i] = (i % 3 == 0) ? 32'h8000_0000 : 32'h7000_0000;
    load_block(w);
    s0 = sym_cnt;
    run_scan("zero", 1'b0);
    check(sym_cnt == s0, "R3 no symbols for zero block", sym_cnt - s0, 0);

    // R3: single full-range negative coefficient at the corner, from plane 27
    foreach (w[i]) w[i] = '0;
    w[CELLS-1] = 32'h8FFF_FFFF;
    load_block(w);
    run_scan("corner", 1'b0);

    // R10: garbage in bits 30:28; R4 R5 R6 sparse random
    foreach (w[i]) w[i] = {$urandom_range(1) == 1, 3'($urandom), 16'h0, 12'($urandom)};
    load_block(w);
    run_scan("sparse", 1'b0);

    // R8 backpressure on a wide range
    bp_mode = 1'b1;
    foreach (w[i]) w[i] = {$urandom_range(1) == 1, 3'b000, 28'($urandom) >> $urandom_range(27)};
    load_block(w);
    run_scan("wide", 1'b0);

    // dense small magnitudes: many significant neighbours across stripes
    foreach (w[i]) w[i] = {$urandom_range(1) == 1, 29'd0, 2'($urandom)};
    load_block(w);
    run_scan("dense", 1'b0);

    // R10: load and start during a scan are ignored; flags persist on restart
    foreach (w[i]) w[i] = {$urandom_range(1) == 1, 3'($urandom), 20'h0, 8'($urandom)};
    load_block(w);
    run_scan("busy", 1'b1);
    run_scan("restart", 1'b0);

    bp_mode = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule